// File: doc/BRIEF.md
# System Register Access Trap Router

This unit decides, for each system-register or maintenance-operation access that a core issues, whether the access may proceed or must be redirected to a higher privilege level. The three possible targets are the supervisor (level 1), the hypervisor (level 2) and the secure monitor (level 3). The core presents one access per cycle with a valid strobe. The access carries a register-class code, the current exception level, a read/write flag, the 16-bit instruction immediate and the secure-state flag. The core also supplies the relevant trap-control bits. The unit returns a registered verdict one cycle later.

When an access traps, the unit also produces the exception class and the syndrome value that the exception entry logic needs. Register storage, exception entry and the mapping of instruction encodings onto register classes belong to neighbouring blocks.

Register-class codes on `acc_class`: 0 = no trap control, 1 = FP control/status, 2 = coprocessor access control, 3 = hypervisor trap-control register, 4 = virtual-memory control group, 5 = TLB invalidate, 6 = cache maintenance to point of unification, 7 = cache maintenance to point of coherency, 8 = set/way cache maintenance, 9 = auxiliary control, 10 = ID group 1, 11 = ID group 2, 12 = ID group 3. Codes 13 to 15 are unused.

Top module: `sysreg_trap_router`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `acc_valid` high. `trap_target`, `exc_class` and `syndrome` load only on a valid access and otherwise hold. Reset clears all outputs to zero.
- R2: `trap_target` is encoded as 0 = allowed, 1 = supervisor, 2 = hypervisor, 3 = monitor. The supervisor check takes precedence over the hypervisor check, which takes precedence over the monitor check.
- R3: An FP control/status access traps to the supervisor in two cases: at level 0 when `fp_enable` is not 3, and at level 1 when `fp_enable[0]` is 0. There is no supervisor trap at levels 2 and 3.
- R4: FP/SIMD-class traps report exception class 0x07 with syndrome 0x1E00000. Every other trap reports class 0x18 with the immediate zero-extended as syndrome. An allowed access reports class 0 and syndrome 0.
- R5: The hypervisor check applies only when `virt_present` is 1 and `in_secure` is 0, and only at level 0 or 1.
- R6: A virtual-memory control group access at level 1 traps to the hypervisor under two conditions: a read when `hyp_cfg[0]` is set, and a write when `hyp_cfg[1]` is set.
- R7: Hypervisor maintenance traps are as follows. TLB invalidate traps at level 1 under `hyp_cfg[2]`. Point-of-unification maintenance traps at level 0 or 1 under `hyp_cfg[3]`. Point-of-coherency maintenance traps at level 0 or 1 under `hyp_cfg[4]`. Set/way maintenance traps at level 1 only under `hyp_cfg[5]`.
- R8: ID accesses trap to the hypervisor under a separate bit per group. Group 1 traps at level 1 under `hyp_cfg[7]`. Group 2 traps at level 0 or 1 under `hyp_cfg[8]`. Group 3 traps at level 1 under `hyp_cfg[9]`.
- R9: At the hypervisor check, FP control/status traps at any applicable level under `hyp_fp_trap`. Coprocessor access control traps at level 1 under `hyp_acc_trap`. Auxiliary control traps at level 1 under `hyp_cfg[6]`.
- R10: The monitor check applies only when `sec_present` is 1. Under that check, FP control/status traps under `mon_fp_trap`. Coprocessor access control traps at level 1 or 2 under `mon_acc_trap`. The hypervisor trap-control register traps at level 2 only under `mon_acc_trap`.
- R11: A write to ID group 1 or ID group 3 never traps.
- R12: Class codes 0, 13, 14 and 15 never trap, whatever the control bits and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_class | input | 4 | Register-class code |
| acc_level | input | 2 | Current exception level |
| acc_read | input | 1 | 1 = read, 0 = write |
| acc_imm | input | 16 | Instruction immediate |
| in_secure | input | 1 | Core is in secure state |
| virt_present | input | 1 | Virtualization level implemented |
| sec_present | input | 1 | Security level implemented |
| fp_enable | input | 2 | Supervisor FP access enable field |
| hyp_fp_trap | input | 1 | Hypervisor FP trap bit |
| hyp_acc_trap | input | 1 | Hypervisor access-control trap bit |
| hyp_cfg | input | 10 | Hypervisor configuration trap bits (see R6 to R9) |
| mon_fp_trap | input | 1 | Monitor FP trap bit |
| mon_acc_trap | input | 1 | Monitor access-control trap bit |
| out_valid | output | 1 | Verdict valid |
| trap_target | output | 2 | Trap destination code |
| exc_class | output | 6 | Exception class |
| syndrome | output | 25 | Syndrome value |

## Verification
The directed tasks target the level boundaries that separate "level 1 only" from "level 1 or below". A design that swapped the two rules would trap set/way or TLB operations at level 0, or would miss point-of-unification traps. The tasks also drive a single FP access against all three checks at once. A wrong priority order would then send the access to the monitor, or would report the immediate instead of the fixed FP syndrome. The bench exercises secure state, level 2 and the missing-virtualization case against a hypervisor bit that would otherwise fire. It also writes to read-only ID groups with their trap bits set, where a careless unit would raise a spurious hypervisor trap. A randomized sweep against a behavioural model covers the remaining combinations.

// File: rtl/sysreg_trap_router.sv
module sysreg_trap_router #(
  parameter int CLASS_W = 4,
  parameter int IMM_W   = 16,
  parameter int EC_W    = 6,
  parameter int SYN_W   = 25,
  parameter int HCFG_W  = 10,
  parameter logic [EC_W-1:0]  EC_FPSIMD   = 6'h07,
  parameter logic [EC_W-1:0]  EC_SYSREG   = 6'h18,
  parameter logic [SYN_W-1:0] FP_SYNDROME = 25'h1E00000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [CLASS_W-1:0] acc_class,
  input  logic [1:0]         acc_level,
  input  logic               acc_read,
  input  logic [IMM_W-1:0]   acc_imm,
  input  logic               in_secure,
  input  logic               virt_present,
  input  logic               sec_present,
  input  logic [1:0]         fp_enable,
  input  logic               hyp_fp_trap,
  input  logic               hyp_acc_trap,
  input  logic [HCFG_W-1:0]  hyp_cfg,
  input  logic               mon_fp_trap,
  input  logic               mon_acc_trap,
  output logic               out_valid,
  output logic [1:0]         trap_target,
  output logic [EC_W-1:0]    exc_class,
  output logic [SYN_W-1:0]   syndrome
);

  localparam logic [CLASS_W-1:0] C_FP     = CLASS_W'(1);
  localparam logic [CLASS_W-1:0] C_ACC    = CLASS_W'(2);
  localparam logic [CLASS_W-1:0] C_HYPCTL = CLASS_W'(3);
  localparam logic [CLASS_W-1:0] C_VM     = CLASS_W'(4);
  localparam logic [CLASS_W-1:0] C_TLBI   = CLASS_W'(5);
  localparam logic [CLASS_W-1:0] C_POU    = CLASS_W'(6);
  localparam logic [CLASS_W-1:0] C_POC    = CLASS_W'(7);
  localparam logic [CLASS_W-1:0] C_SW     = CLASS_W'(8);
  localparam logic [CLASS_W-1:0] C_AUX    = CLASS_W'(9);
  localparam logic [CLASS_W-1:0] C_ID1    = CLASS_W'(10);
  localparam logic [CLASS_W-1:0] C_ID2    = CLASS_W'(11);
  localparam logic [CLASS_W-1:0] C_ID3    = CLASS_W'(12);

  localparam int B_RD_VM = 0, B_WR_VM = 1, B_TLB = 2, B_POU = 3, B_POC = 4;
  localparam int B_SW = 5, B_AUX = 6, B_ID1 = 7, B_ID2 = 8, B_ID3 = 9;

  localparam logic [1:0] T_NONE = 2'd0, T_SUP = 2'd1, T_HYP = 2'd2, T_MON = 2'd3;

  logic lvl0, lvl1, lvl2, low;
  assign lvl0 = (acc_level == 2'd0);
  assign lvl1 = (acc_level == 2'd1);
  assign lvl2 = (acc_level == 2'd2);
  assign low  = lvl0 | lvl1;

  logic is_fp, ro_write;
  assign is_fp    = (acc_class == C_FP);
  assign ro_write = !acc_read && ((acc_class == C_ID1) || (acc_class == C_ID3));

  logic sup_hit;
  assign sup_hit = is_fp && ((lvl0 && fp_enable != 2'b11) || (lvl1 && !fp_enable[0]));

  logic hyp_cond;
  always_comb begin
    hyp_cond = 1'b0;
    case (acc_class)
      C_FP:   hyp_cond = hyp_fp_trap;
      C_ACC:  hyp_cond = hyp_acc_trap && lvl1;
      C_VM:   hyp_cond = lvl1 && (acc_read ? hyp_cfg[B_RD_VM] : hyp_cfg[B_WR_VM]);
      C_TLBI: hyp_cond = hyp_cfg[B_TLB] && lvl1;
      C_POU:  hyp_cond = hyp_cfg[B_POU] && low;
      C_POC:  hyp_cond = hyp_cfg[B_POC] && low;
      C_SW:   hyp_cond = hyp_cfg[B_SW] && lvl1;
      C_AUX:  hyp_cond = hyp_cfg[B_AUX] && lvl1;
      C_ID1:  hyp_cond = hyp_cfg[B_ID1] && lvl1;
      C_ID2:  hyp_cond = hyp_cfg[B_ID2] && low;
      C_ID3:  hyp_cond = hyp_cfg[B_ID3] && lvl1;
      default: hyp_cond = 1'b0;
    endcase
  end

  logic hyp_en, hyp_hit;
  assign hyp_en  = virt_present && !in_secure && (acc_level <= 2'd2) && !lvl2;
  assign hyp_hit = hyp_en && hyp_cond && !ro_write;

  logic mon_cond, mon_hit;
  always_comb begin
    mon_cond = 1'b0;
    case (acc_class)
      C_FP:     mon_cond = mon_fp_trap;
      C_ACC:    mon_cond = mon_acc_trap && (lvl1 || lvl2);
      C_HYPCTL: mon_cond = mon_acc_trap && lvl2;
      default:  mon_cond = 1'b0;
    endcase
  end
  // every level is at or below the monitor, so only presence gates it
  assign mon_hit = sec_present && mon_cond;

  logic [1:0]       nxt_target;
  logic [EC_W-1:0]  nxt_class;
  logic [SYN_W-1:0] nxt_syn;
  always_comb begin
    nxt_target = T_NONE;
    nxt_class  = '0;
    nxt_syn    = '0;
    if (sup_hit) begin
      nxt_target = T_SUP;
      nxt_class  = EC_FPSIMD;
      nxt_syn    = FP_SYNDROME;
    end else if (hyp_hit || mon_hit) begin
      nxt_target = hyp_hit ? T_HYP : T_MON;
      nxt_class  = is_fp ? EC_FPSIMD : EC_SYSREG;
      nxt_syn    = is_fp ? FP_SYNDROME : SYN_W'(acc_imm);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      trap_target <= T_NONE;
      exc_class   <= '0;
      syndrome    <= '0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) begin
        trap_target <= nxt_target;
        exc_class   <= nxt_class;
        syndrome    <= nxt_syn;
      end
    end
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> out_valid);
  p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !out_valid);
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(trap_target) && $stable(syndrome));
  p_sup_fp_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_target == T_SUP |-> exc_class == EC_FPSIMD && syndrome == FP_SYNDROME);
  p_clean_allow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_target == T_NONE |-> exc_class == '0 && syndrome == '0);
  p_imm_syndrome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_target != T_NONE && exc_class == EC_SYSREG |->
      syndrome == SYN_W'($past(acc_imm)));
  p_hyp_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_target == T_HYP |->
      $past(virt_present) && !$past(in_secure) && $past(acc_level) <= 2'd1);
  p_mon_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_target == T_MON |-> $past(sec_present));
  p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(acc_read) &&
      ($past(acc_class) == C_ID1 || $past(acc_class) == C_ID3) |-> trap_target == T_NONE);

endmodule

// File: tb/sysreg_trap_router_test.sv
module sysreg_trap_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [3:0] acc_class = '0;
  logic [1:0] acc_level = '0;
  logic acc_read = 1'b1;
  logic [15:0] acc_imm = '0;
  logic in_secure = 1'b0, virt_present = 1'b0, sec_present = 1'b0;
  logic [1:0] fp_enable = 2'b11;
  logic hyp_fp_trap = 1'b0, hyp_acc_trap = 1'b0;
  logic [9:0] hyp_cfg = '0;
  logic mon_fp_trap = 1'b0, mon_acc_trap = 1'b0;
  logic out_valid;
  logic [1:0] trap_target;
  logic [5:0] exc_class;
  logic [24:0] syndrome;

  int checks = 0;
  int errors = 0;

  localparam logic [5:0]  ECF = 6'h07;
  localparam logic [5:0]  ECS = 6'h18;
  localparam logic [24:0] FSY = 25'h1E00000;

  always #10 clk = ~clk;

  sysreg_trap_router uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_class(acc_class),
    .acc_level(acc_level), .acc_read(acc_read), .acc_imm(acc_imm),
    .in_secure(in_secure), .virt_present(virt_present), .sec_present(sec_present),
    .fp_enable(fp_enable), .hyp_fp_trap(hyp_fp_trap), .hyp_acc_trap(hyp_acc_trap),
    .hyp_cfg(hyp_cfg), .mon_fp_trap(mon_fp_trap), .mon_acc_trap(mon_acc_trap),
    .out_valid(out_valid), .trap_target(trap_target), .exc_class(exc_class),
    .syndrome(syndrome));

  task automatic chk(input string req, input logic v, input logic [1:0] t,
                     input logic [5:0] ec, input logic [24:0] sy);
    checks++;
    if (out_valid !== v || trap_target !== t || exc_class !== ec || syndrome !== sy) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%0d ec=%h syn=%h, expected v=%0b t=%0d ec=%h syn=%h",
               req, out_valid, trap_target, exc_class, syndrome, v, t, ec, sy);
    end
  endtask

  task automatic quiet();
    in_secure = 0; virt_present = 1; sec_present = 1; fp_enable = 2'b11;
    hyp_fp_trap = 0; hyp_acc_trap = 0; hyp_cfg = '0; mon_fp_trap = 0; mon_acc_trap = 0;
    acc_read = 1; acc_imm = 16'hA5C3;
  endtask

  task automatic go(input logic [3:0] c, input logic [1:0] l);
    @(negedge clk);
    acc_class = c; acc_level = l; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
  endtask

  function automatic logic [32:0] model();
    logic l0, l1, lo, s, h, m, fp;
    l0 = acc_level == 0; l1 = acc_level == 1; lo = l0 | l1;
    fp = acc_class == 1;
    s = fp && ((l0 && fp_enable != 3) || (l1 && !fp_enable[0]));
    case (acc_class)
      1: h = hyp_fp_trap;
      2: h = hyp_acc_trap && l1;
      4: h = l1 && (acc_read ? hyp_cfg[0] : hyp_cfg[1]);
      5: h = hyp_cfg[2] && l1;
      6: h = hyp_cfg[3] && lo;
      7: h = hyp_cfg[4] && lo;
      8: h = hyp_cfg[5] && l1;
      9: h = hyp_cfg[6] && l1;
      10: h = hyp_cfg[7] && l1 && acc_read;
      11: h = hyp_cfg[8] && lo;
      12: h = hyp_cfg[9] && l1 && acc_read;
      default: h = 0;
    endcase
    h = h && virt_present && !in_secure && lo;
    case (acc_class)
      1: m = mon_fp_trap;
      2: m = mon_acc_trap && (acc_level == 1 || acc_level == 2);
      3: m = mon_acc_trap && acc_level == 2;
      default: m = 0;
    endcase
    m = m && sec_present;
    if (s) return {2'd1, ECF, FSY};
    if (h || m) return {h ? 2'd2 : 2'd3, fp ? ECF : ECS, fp ? FSY : {9'b0, acc_imm}};
    return '0;
  endfunction

  task automatic t_reset();
    chk("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic t_timing();
    quiet(); fp_enable = 0;
    go(1, 0);
    chk("R1 valid after strobe", 1, 1, ECF, FSY);
    @(negedge clk);
    fp_enable = 3; acc_class = 0;
    chk("R1 hold while idle", 0, 1, ECF, FSY);
  endtask

  task automatic t_sup_fp();
    quiet(); virt_present = 0; sec_present = 0;
    fp_enable = 3; go(1, 0); chk("R3 L0 enable=3", 1, 0, 0, 0);
    fp_enable = 1; go(1, 0); chk("R3 L0 enable=1", 1, 1, ECF, FSY);
    go(1, 1); chk("R3 L1 enable=1", 1, 0, 0, 0);
    fp_enable = 2; go(1, 1); chk("R3 L1 enable=2", 1, 1, ECF, FSY);
    fp_enable = 0; go(1, 2); chk("R3 L2 no supervisor", 1, 0, 0, 0);
  endtask

  task automatic t_priority();
    quiet(); fp_enable = 0; hyp_fp_trap = 1; mon_fp_trap = 1;
    go(1, 1); chk("R2 supervisor first", 1, 1, ECF, FSY);
    fp_enable = 1; go(1, 1); chk("R2 hypervisor before monitor", 1, 2, ECF, FSY);
    hyp_fp_trap = 0; go(1, 1); chk("R2 monitor last", 1, 3, ECF, FSY);
  endtask

  task automatic t_hyp_gate();
    quiet(); hyp_cfg[1] = 1; acc_read = 0; acc_imm = 16'h1234;
    go(4, 1); chk("R4 imm syndrome", 1, 2, ECS, 25'h1234);
    in_secure = 1; go(4, 1); chk("R5 secure blocks", 1, 0, 0, 0);
    in_secure = 0; virt_present = 0; go(4, 1); chk("R5 no virt blocks", 1, 0, 0, 0);
    virt_present = 1; go(4, 2); chk("R5 level2 blocks", 1, 0, 0, 0);
    go(4, 3); chk("R5 level3 blocks", 1, 0, 0, 0);
  endtask

  task automatic t_vm();
    quiet(); hyp_cfg[0] = 1;
    go(4, 1); chk("R6 read trap", 1, 2, ECS, 25'hA5C3);
    acc_read = 0; go(4, 1); chk("R6 write ignores read bit", 1, 0, 0, 0);
    hyp_cfg = 10'b10; acc_read = 1; go(4, 1); chk("R6 read ignores write bit", 1, 0, 0, 0);
    acc_read = 0; go(4, 0); chk("R6 level0 write", 1, 0, 0, 0);
  endtask

  task automatic t_maint();
    quiet(); hyp_cfg[2] = 1;
    go(5, 0); chk("R7 tlbi L0", 1, 0, 0, 0);
    go(5, 1); chk("R7 tlbi L1", 1, 2, ECS, 25'hA5C3);
    hyp_cfg = 10'b1000; go(6, 0); chk("R7 pou L0", 1, 2, ECS, 25'hA5C3);
    go(7, 0); chk("R7 poc under pou bit", 1, 0, 0, 0);
    hyp_cfg = 10'b10000; go(7, 0); chk("R7 poc L0", 1, 2, ECS, 25'hA5C3);
    hyp_cfg = 10'b100000; go(8, 0); chk("R7 setway L0", 1, 0, 0, 0);
    go(8, 1); chk("R7 setway L1", 1, 2, ECS, 25'hA5C3);
  endtask

  task automatic t_id();
    quiet(); hyp_cfg[9] = 1;
    go(12, 0); chk("R8 id3 L0", 1, 0, 0, 0);
    go(12, 1); chk("R8 id3 L1", 1, 2, ECS, 25'hA5C3);
    go(10, 1); chk("R8 id1 under id3 bit", 1, 0, 0, 0);
    hyp_cfg = 10'b0100000000; go(11, 0); chk("R8 id2 L0", 1, 2, ECS, 25'hA5C3);
    hyp_cfg = 10'b0010000000; go(10, 1); chk("R8 id1 L1", 1, 2, ECS, 25'hA5C3);
    go(10, 0); chk("R8 id1 L0", 1, 0, 0, 0);
  endtask

  task automatic t_hyp_misc();
    quiet(); hyp_fp_trap = 1;
    go(1, 0); chk("R9 fp to hyp L0", 1, 2, ECF, FSY);
    hyp_fp_trap = 0; hyp_acc_trap = 1;
    go(2, 1); chk("R9 acc L1", 1, 2, ECS, 25'hA5C3);
    go(2, 0); chk("R9 acc L0", 1, 0, 0, 0);
    hyp_acc_trap = 0; hyp_cfg[6] = 1;
    go(9, 1); chk("R9 aux L1", 1, 2, ECS, 25'hA5C3);
    go(9, 0); chk("R9 aux L0", 1, 0, 0, 0);
  endtask

  task automatic t_mon();
    quiet(); mon_fp_trap = 1;
    go(1, 3); chk("R10 fp L3", 1, 3, ECF, FSY);
    sec_present = 0; go(1, 3); chk("R10 no security", 1, 0, 0, 0);
    sec_present = 1; mon_fp_trap = 0; mon_acc_trap = 1;
    go(2, 2); chk("R10 acc L2", 1, 3, ECS, 25'hA5C3);
    go(2, 0); chk("R10 acc L0", 1, 0, 0, 0);
    go(2, 3); chk("R10 acc L3", 1, 0, 0, 0);
    go(3, 2); chk("R10 hypctl L2", 1, 3, ECS, 25'hA5C3);
    go(3, 1); chk("R10 hypctl L1", 1, 0, 0, 0);
  endtask

  task automatic t_ro_write();
    quiet(); hyp_cfg = '1; acc_read = 0;
    go(12, 1); chk("R11 write id3", 1, 0, 0, 0);
    go(10, 1); chk("R11 write id1", 1, 0, 0, 0);
    acc_read = 1; go(10, 1); chk("R11 read id1 still traps", 1, 2, ECS, 25'hA5C3);
  endtask

  task automatic t_unknown();
    quiet(); hyp_cfg = '1; hyp_fp_trap = 1; hyp_acc_trap = 1;
    mon_fp_trap = 1; mon_acc_trap = 1; fp_enable = 0;
    for (int c = 13; c < 17; c++) begin
      for (int l = 0; l < 4; l++) begin
        go(4'(c), 2'(l)); chk("R12 inert class", 1, 0, 0, 0);
      end
    end
  endtask

  task automatic t_sweep();
    logic [32:0] e;
    for (int i = 0; i < 400; i++) begin
      acc_read = 1'($urandom); acc_imm = 16'($urandom);
      in_secure = 1'($urandom); virt_present = 1'($urandom); sec_present = 1'($urandom);
      fp_enable = 2'($urandom); hyp_fp_trap = 1'($urandom); hyp_acc_trap = 1'($urandom);
      hyp_cfg = 10'($urandom); mon_fp_trap = 1'($urandom); mon_acc_trap = 1'($urandom);
      @(negedge clk);
      acc_class = 4'($urandom); acc_level = 2'($urandom);
      e = model();
      acc_valid = 1;
      @(negedge clk);
      acc_valid = 0;
      chk("R2 random sweep", 1, e[32:31], e[30:25], e[24:0]);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_sup_fp();
    t_priority();
    t_hyp_gate();
    t_vm();
    t_maint();
    t_id();
    t_hyp_misc();
    t_mon();
    t_ro_write();
    t_unknown();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule